// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This block brings a serial transceiver channel out of reset when the channel has both a transmit and a receive path and the receive clock-data-recovery unit locks on its own. It drives four active-high reset lines: PLL analog reset, transmit digital reset, receive analog reset and receive digital reset. It releases them one stage at a time, and each stage waits for a status input. When every reset is released it raises a ready flag, and from then on data may flow.

The three status inputs are PLL locked, reconfiguration busy and receive frequency locked. They may arrive from any clock domain, so each passes through a two-flop synchroniser before the sequencer uses it. Three minimum times are parameters counted in clock cycles: how long the PLL reset is held, the gap that must follow the end of busy, and the settle time after frequency lock. If the PLL loses lock, the sequence starts again from the beginning. If the receiver loses frequency lock, only the receive path is reset again. The synchronous reset input returns everything to the power-up state.

Top module: `xcvr_bringup_seq`

## Requirements
- R1: While `srst` is high, every rising edge leaves all four reset outputs at 1 and `link_ready_o` at 0.
- R2: `pll_rst_o` deasserts on the HOLD_CYC-th rising edge after `srst` is first sampled low, or after a restart. While `pll_rst_o` is 1, the other three reset outputs are also 1.
- R3: `tx_drst_o` stays at 1 while `pll_lock_i` is low. It deasserts on the 3rd rising edge after `pll_lock_i` rises, which is two synchroniser stages plus one state update.
- R4: `rx_arst_o` needs synchronised busy to be low for BUSY_GAP consecutive cycles after `tx_drst_o` has fallen. If busy is already low, it falls BUSY_GAP cycles after `tx_drst_o`. Otherwise it falls BUSY_GAP+2 cycles after `recfg_busy_i` falls, and a busy pulse shorter than that restarts the count.
- R5: `rx_drst_o` stays at 1 until frequency lock. It deasserts SETTLE_CYC+3 cycles after `rx_flock_i` rises, provided the input stays high.
- R6: `link_ready_o` is 1 exactly when all four reset outputs are 0.
- R7: If `rx_flock_i` drops during the settle wait, the wait restarts. `rx_drst_o` then falls SETTLE_CYC+3 cycles after the input rises again.
- R8: If frequency lock is lost after ready, then 3 cycles later `rx_arst_o` and `rx_drst_o` are 1, `link_ready_o` is 0, and `tx_drst_o` and `pll_rst_o` stay 0. `rx_arst_o` is then released again under R4 without a new busy pulse.
- R9: If `pll_lock_i` falls after `tx_drst_o` has been released, then 3 cycles later all four resets are 1 and the sequence restarts under R2.
- R10: `srst` raised at any point of the sequence gives the R1 output state one cycle later.
- R11: `rx_arst_o` is never 0 while `tx_drst_o` is 1, and `rx_drst_o` is never 0 while `rx_arst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| srst | input | 1 | Synchronous active-high restart |
| pll_lock_i | input | 1 | PLL locked status, asynchronous |
| recfg_busy_i | input | 1 | Reconfiguration/calibration busy, asynchronous |
| rx_flock_i | input | 1 | Receive frequency locked, asynchronous |
| pll_rst_o | output | 1 | PLL analog reset |
| tx_drst_o | output | 1 | Transmit digital reset |
| rx_arst_o | output | 1 | Receive analog reset |
| rx_drst_o | output | 1 | Receive digital reset |
| link_ready_o | output | 1 | Channel ready for traffic |

## Verification
After a status input changes, the outputs respond on the third rising edge: two edges pass through the synchroniser and the state update takes the third. The busy gap adds BUSY_GAP edges to this, and the settle wait adds SETTLE_CYC. The PLL hold ends on the HOLD_CYC-th edge after release. The bench drives its inputs just after a falling edge and counts falling edges until each output changes. It compares that count with the sum worked out from the parameters. It repeats this over a sweep of busy delays, busy glitches and the position of the frequency-lock drop.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_PLL_HOLD,
        ST_PLL_WAIT,
        ST_RXA_WAIT,
        ST_FLOCK_WAIT,
        ST_SETTLE,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic pll;
        logic txd;
        logic rxa;
        logic rxd;
        logic rdy;
    } ctl_vec_t;

    typedef struct packed {
        logic pll_lock;
        logic busy;
        logic flock;
    } stat_vec_t;

    function automatic ctl_vec_t ctl_for(seq_state_e s);
        ctl_vec_t v;
        v = '{pll: 1'b1, txd: 1'b1, rxa: 1'b1, rxd: 1'b1, rdy: 1'b0};
        case (s)
            ST_PLL_HOLD:   v = '{pll: 1'b1, txd: 1'b1, rxa: 1'b1, rxd: 1'b1, rdy: 1'b0};
            ST_PLL_WAIT:   v = '{pll: 1'b0, txd: 1'b1, rxa: 1'b1, rxd: 1'b1, rdy: 1'b0};
            ST_RXA_WAIT:   v = '{pll: 1'b0, txd: 1'b0, rxa: 1'b1, rxd: 1'b1, rdy: 1'b0};
            ST_FLOCK_WAIT,
            ST_SETTLE:     v = '{pll: 1'b0, txd: 1'b0, rxa: 1'b0, rxd: 1'b1, rdy: 1'b0};
            ST_READY:      v = '{pll: 1'b0, txd: 1'b0, rxa: 1'b0, rxd: 1'b0, rdy: 1'b1};
            default:       ;
        endcase
        return v;
    endfunction

    function automatic bit lock_required(seq_state_e s);
        return (s != ST_PLL_HOLD) && (s != ST_PLL_WAIT);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (srst) stg[i] <= '0;
                else      stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (srst) stg[i] <= '0;
                else      stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = (cnt == (limit - CW'(1)));

    always_ff @(posedge clk) begin
        if (srst || clr)  cnt <= '0;
        else if (!done)   cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
    import xrs_pkg::*;
#(
    parameter int HOLD_CYC   = 125,
    parameter int BUSY_GAP   = 2,
    parameter int SETTLE_CYC = 500,
    parameter int CW         = 9
) (
    input  logic          clk,
    input  logic          srst,
    input  stat_vec_t     st,
    input  logic          tmr_done,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_limit,
    output ctl_vec_t      ctl
);
    seq_state_e state, nxt;

    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        case (state)
            ST_PLL_HOLD:
                if (tmr_done) begin nxt = ST_PLL_WAIT; tmr_clr = 1'b1; end
            ST_PLL_WAIT:
                if (st.pll_lock) begin nxt = ST_RXA_WAIT; tmr_clr = 1'b1; end
            ST_RXA_WAIT:
                if (st.busy)          tmr_clr = 1'b1;
                else if (tmr_done) begin nxt = ST_FLOCK_WAIT; tmr_clr = 1'b1; end
            ST_FLOCK_WAIT:
                if (st.flock) begin nxt = ST_SETTLE; tmr_clr = 1'b1; end
            ST_SETTLE:
                if (!st.flock)     begin nxt = ST_FLOCK_WAIT; tmr_clr = 1'b1; end
                else if (tmr_done) begin nxt = ST_READY;      tmr_clr = 1'b1; end
            ST_READY:
                if (!st.flock) begin nxt = ST_RXA_WAIT; tmr_clr = 1'b1; end
            default: begin nxt = ST_PLL_HOLD; tmr_clr = 1'b1; end
        endcase
        if (lock_required(state) && !st.pll_lock) begin
            nxt     = ST_PLL_HOLD;
            tmr_clr = 1'b1;
        end
    end

    always_comb begin
        case (state)
            ST_RXA_WAIT: tmr_limit = CW'(BUSY_GAP);
            ST_SETTLE:   tmr_limit = CW'(SETTLE_CYC);
            default:     tmr_limit = CW'(HOLD_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state <= ST_PLL_HOLD;
            ctl   <= ctl_for(ST_PLL_HOLD);
        end else begin
            state <= nxt;
            ctl   <= ctl_for(nxt);
        end
    end
endmodule

// File: rtl/xcvr_bringup_seq.sv
module xcvr_bringup_seq
    import xrs_pkg::*;
#(
    parameter int HOLD_CYC   = 125,
    parameter int BUSY_GAP   = 2,
    parameter int SETTLE_CYC = 500,
    parameter int SYNC_STG   = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic pll_lock_i,
    input  logic recfg_busy_i,
    input  logic rx_flock_i,
    output logic pll_rst_o,
    output logic tx_drst_o,
    output logic rx_arst_o,
    output logic rx_drst_o,
    output logic link_ready_o
);
    localparam int CW = $clog2(max3(HOLD_CYC, BUSY_GAP, SETTLE_CYC) + 1);
    localparam int SW = $bits(stat_vec_t);

    stat_vec_t     st_raw, st_sync;
    logic [SW-1:0] sync_q;
    logic          tmr_clr, tmr_done;
    logic [CW-1:0] tmr_limit;
    ctl_vec_t      ctl;

    assign st_raw = '{pll_lock: pll_lock_i, busy: recfg_busy_i, flock: rx_flock_i};

    xrs_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
        .clk (clk), .srst(srst), .d(st_raw), .q(sync_q)
    );
    assign st_sync = stat_vec_t'(sync_q);

    xrs_timer #(.CW(CW)) u_tmr (
        .clk(clk), .srst(srst), .clr(tmr_clr), .limit(tmr_limit), .done(tmr_done)
    );

    xrs_fsm #(
        .HOLD_CYC(HOLD_CYC), .BUSY_GAP(BUSY_GAP), .SETTLE_CYC(SETTLE_CYC), .CW(CW)
    ) u_fsm (
        .clk(clk), .srst(srst), .st(st_sync), .tmr_done(tmr_done),
        .tmr_clr(tmr_clr), .tmr_limit(tmr_limit), .ctl(ctl)
    );

    assign pll_rst_o    = ctl.pll;
    assign tx_drst_o    = ctl.txd;
    assign rx_arst_o    = ctl.rxa;
    assign rx_drst_o    = ctl.rxd;
    assign link_ready_o = ctl.rdy;
endmodule

// File: rtl/xrs_chk.sv
module xrs_chk (
    input logic clk,
    input logic srst,
    input logic pll_lock_i,
    input logic recfg_busy_i,
    input logic rx_flock_i,
    input logic pll_rst_o,
    input logic tx_drst_o,
    input logic rx_arst_o,
    input logic rx_drst_o,
    input logic link_ready_o
);
    logic srst_q;
    always_ff @(posedge clk) srst_q <= srst;

    always_ff @(posedge clk) begin
        if (srst_q) begin
            AST_RESET_STATE: assert ({pll_rst_o, tx_drst_o, rx_arst_o, rx_drst_o, link_ready_o} == 5'b11110); // R1
        end
    end

    AST_PLL_HOLDS_ALL: assert property (@(posedge clk) disable iff (srst)
        pll_rst_o |-> (tx_drst_o && rx_arst_o && rx_drst_o)); // R2

    AST_TX_AFTER_LOCK: assert property (@(posedge clk) disable iff (srst)
        $fell(tx_drst_o) |-> $past(pll_lock_i, 2)); // R3

    AST_RXA_BUSY_IDLE: assert property (@(posedge clk) disable iff (srst)
        $fell(rx_arst_o) |-> (!$past(recfg_busy_i, 2) && !$past(recfg_busy_i, 3))); // R4

    AST_RXD_AFTER_FLOCK: assert property (@(posedge clk) disable iff (srst)
        $fell(rx_drst_o) |-> $past(rx_flock_i, 2)); // R5

    AST_READY_MATCH: assert property (@(posedge clk) disable iff (srst)
        link_ready_o == !(pll_rst_o || tx_drst_o || rx_arst_o || rx_drst_o)); // R6

    AST_RXA_ORDER: assert property (@(posedge clk) disable iff (srst)
        !rx_arst_o |-> !tx_drst_o); // R11

    AST_RXD_ORDER: assert property (@(posedge clk) disable iff (srst)
        !rx_drst_o |-> !rx_arst_o); // R11
endmodule

bind xcvr_bringup_seq xrs_chk u_chk (
    .clk(clk), .srst(srst), .pll_lock_i(pll_lock_i), .recfg_busy_i(recfg_busy_i),
    .rx_flock_i(rx_flock_i), .pll_rst_o(pll_rst_o), .tx_drst_o(tx_drst_o),
    .rx_arst_o(rx_arst_o), .rx_drst_o(rx_drst_o), .link_ready_o(link_ready_o)
);

// File: tb/sim_xcvr_bringup_seq.sv
`timescale 1ns/1ps
module sim_xcvr_bringup_seq;
    localparam int HOLD   = 6;
    localparam int GAP    = 2;
    localparam int SETTLE = 5;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic pll_lock = 1'b0, busy = 1'b0, flock = 1'b0;
    logic pll_rst, tx_drst, rx_arst, rx_drst, rdy;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    xcvr_bringup_seq #(.HOLD_CYC(HOLD), .BUSY_GAP(GAP), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .srst(srst), .pll_lock_i(pll_lock), .recfg_busy_i(busy),
        .rx_flock_i(flock), .pll_rst_o(pll_rst), .tx_drst_o(tx_drst),
        .rx_arst_o(rx_arst), .rx_drst_o(rx_drst), .link_ready_o(rdy)
    );

    function automatic logic [4:0] outs();
        return {pll_rst, tx_drst, rx_arst, rx_drst, rdy};
    endfunction

    function automatic logic pick(int which);
        case (which)
            0: return pll_rst;
            1: return tx_drst;
            2: return rx_arst;
            default: return rx_drst;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic negs_until(int which, logic lvl, output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (pick(which) == lvl) begin n = i; break; end
        end
    endtask

    // R2 / R6 / R11 continuous checks on every falling edge
    always @(negedge clk) begin
        if (!srst && !finished) begin
            if (pll_rst && !(tx_drst && rx_arst && rx_drst))
                check("R2 others held with pll reset", outs(), 5'b11110);
            if (rdy != !(pll_rst || tx_drst || rx_arst || rx_drst))
                check("R6 ready consistency", rdy, !rdy);
            if ((!rx_arst && tx_drst) || (!rx_drst && rx_arst))
                check("R11 release order", outs(), 0);
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", outs(), 5'b11110);

        for (int t = 0; t < 6; t++) begin
            int d = t % 4;
            int q = 1 + ((t - 1) % SETTLE);
            // restart with srst (R10 when coming from a running sequence)
            srst = 1'b1; pll_lock = 1'b0; flock = 1'b0; busy = (d != 0);
            @(negedge clk);
            check("R10 srst restart state", outs(), 5'b11110);
            srst = 1'b0;
            negs_until(0, 1'b0, n);
            check("R2 pll hold length", n, HOLD);
            repeat (4) @(negedge clk);
            check("R3 tx held without lock", tx_drst, 1);
            pll_lock = 1'b1;
            negs_until(1, 1'b0, n);
            check("R3 tx release latency", n, 3);
            if (d == 0) begin
                negs_until(2, 1'b0, n);
                check("R4 rx analog gap with busy low", n, GAP);
            end else begin
                repeat (d + 3) @(negedge clk);
                check("R4 rx analog held while busy", rx_arst, 1);
                if (d >= 2) begin
                    busy = 1'b0;
                    @(negedge clk);
                    busy = 1'b1;
                    repeat (5) @(negedge clk);
                    check("R4 short busy gap ignored", rx_arst, 1);
                end
                busy = 1'b0;
                negs_until(2, 1'b0, n);
                check("R4 rx analog after busy fall", n, GAP + 2);
            end
            repeat (3) @(negedge clk);
            check("R5 rx digital held without flock", rx_drst, 1);
            flock = 1'b1;
            if (t == 0) begin
                negs_until(3, 1'b0, n);
                check("R5 settle latency", n, SETTLE + 3);
            end else begin
                repeat (q) @(negedge clk);
                flock = 1'b0;
                @(negedge clk);
                flock = 1'b1;
                negs_until(3, 1'b0, n);
                check("R7 settle restart latency", n, SETTLE + 3);
            end
            check("R6 ready at end", outs(), 5'b00001);

            if (t % 2 == 0) begin
                flock = 1'b0;
                repeat (3) @(negedge clk);
                check("R8 rx resets after flock loss", outs(), 5'b00110);
                negs_until(2, 1'b0, n);
                check("R8 rx analog re-release", n, GAP);
                check("R8 rx digital still held", rx_drst, 1);
                flock = 1'b1;
                negs_until(3, 1'b0, n);
                check("R8 ready again", n, SETTLE + 3);
            end else begin
                pll_lock = 1'b0;
                repeat (3) @(negedge clk);
                check("R9 full restart on lock loss", outs(), 5'b11110);
                negs_until(0, 1'b0, n);
                check("R9 restart hold length", n, HOLD);
            end
            repeat (2) @(negedge clk);
        end
        summary();
    end
endmodule